// File: doc/BRIEF.md
# Externally Clocked Serial Request/Response Port

This block exchanges one byte with a far device over a three-wire link whose serial clock belongs to that device. A launch timer in the system clock domain starts each exchange. The block then presents the transmit byte one bit per serial clock cycle. After a half-duplex pause of variable length, it collects the byte that the device sends back. The serial clock never clocks any flop here. The clock and the incoming data both pass through a multi-stage synchronizer, and their edges are found by comparing consecutive synchronized samples. This makes the serial clock an ordinary sampled signal, and it must be much slower than the system clock.

A sequencer walks through four phases: idle, transmit, waiting for the reply, and receive. The transmit byte is captured at launch only. A reply that never arrives, or that stalls partway through, is cut off by a watchdog count that is set above the longest legal reply delay. When that happens the block returns to idle with a one-cycle error pulse. A complete reply is presented on the receive bus with a one-cycle valid strobe.

Top module: `sreq_port`

## Requirements
- R1: While reset is applied and until the first launch, busy_o, rx_valid_o and err_o are 0 and ser_dat_o is 1.
- R2: Each idle phase lasts exactly PERIOD_CYC system cycles: busy_o is low for exactly PERIOD_CYC consecutive cycles between two busy periods.
- R3: In the transmit phase, each falling serial clock edge makes ser_dat_o present the next bit, most significant bit first. The bit holds steady until the following falling edge, so the device's rising-edge sample of bit k (k = 0 first) is bit DATA_W-1-k of the byte.
- R4: ser_dat_o is 1 in the transmit phase before the first falling edge, and in every phase other than transmit.
- R5: tx_byte_i is sampled only at the cycle of launch; changes to it while busy_o is high do not alter the bits shifted out.
- R6: In the reply, the serial data input is sampled at each rising serial clock edge, most significant bit first. After the DATA_W-th rising edge, rx_byte_o holds the assembled byte and rx_valid_o is high for exactly one cycle. Both appear together, with busy_o already low.
- R7: Any reply delay shorter than TIMEOUT_CYC system cycles, measured from the last transmit rising edge to the first reply rising edge, is accepted.
- R8: If no rising serial clock edge arrives for TIMEOUT_CYC cycles while the block waits for or receives the reply, it returns to idle. err_o pulses high for one cycle, and rx_valid_o stays low.
- R9: busy_o is high throughout the transmit, wait and receive phases, from launch until the cycle rx_valid_o or err_o is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all flops use it |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| ser_clk_i | input | 1 | Serial clock driven by the far device, idle high |
| ser_dat_i | input | 1 | Serial reply data from the device |
| ser_dat_o | output | 1 | Serial request data to the device |
| tx_byte_i | input | DATA_W | Byte sent in the next exchange |
| rx_byte_o | output | DATA_W | Last byte received |
| rx_valid_o | output | 1 | One-cycle strobe when rx_byte_o is updated |
| busy_o | output | 1 | High whenever an exchange is in progress |
| err_o | output | 1 | One-cycle pulse when a reply times out |

## Verification
A wrong bit counter shows up at once as an early or late return to idle. The device model then sees busy_o fall while it is still clocking, or the receive strobe appears one bit shifted, within one serial clock period. A broken shift direction or load condition shows in the transmit byte that the device model reassembles, which is compared at its eighth rising edge. A wrong idle or timeout count shows as a wrong busy-low run length, or as an error pulse outside its window, in the same exchange.

// File: rtl/sreq_pkg.sv
package sreq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TX   = 2'd1,
    ST_WAIT = 2'd2,
    ST_RX   = 2'd3
  } sreq_state_e;

endpackage

// File: rtl/sreq_sync.sv
module sreq_sync #(
  parameter int unsigned       WIDTH   = 1,
  parameter int unsigned       STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("sreq_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= {STAGES{RST_VAL}};
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/sreq_txshift.sv
module sreq_txshift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              active_i,
  input  logic              shift_i,
  output logic              dat_o
);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic              dat_q, dat_d;
  logic              sh_en;

  assign sh_en = load_i | (active_i & shift_i);

  always_comb begin
    sh_d  = sh_q;
    dat_d = dat_q;
    if (load_i) begin
      sh_d  = byte_i;
      dat_d = 1'b1;
    end else if (active_i && shift_i) begin
      sh_d  = {sh_q[DATA_W-2:0], 1'b0};
      dat_d = sh_q[DATA_W-1];
    end else if (!active_i) begin
      dat_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (sh_en) begin
      sh_q <= sh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= 1'b1;
    end else begin
      dat_q <= dat_d;
    end
  end

  assign dat_o = dat_q;

  // R3: a driven bit does not move between falling edges
  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !shift_i && !load_i) |=> $stable(dat_o));

  // R4: line rests high outside the transmit phase
  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_i && $past(!active_i)) |-> dat_o);

endmodule

// File: rtl/sreq_rxshift.sv
module sreq_rxshift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic              last_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] byte_o
);

  logic [DATA_W-1:0] sh_q;
  logic [DATA_W-1:0] out_q;
  logic [DATA_W-1:0] assembled;

  assign assembled = {sh_q[DATA_W-2:0], bit_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (capture_i) begin
      sh_q <= assembled;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (capture_i && last_i) begin
      out_q <= assembled;
    end
  end

  assign byte_o = out_q;

  // R6: the presented byte changes only on completion of a reply
  p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(capture_i && last_i) |=> $stable(byte_o));

endmodule

// File: rtl/sreq_seq.sv
module sreq_seq
  import sreq_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned PERIOD_CYC  = 50000,
  parameter int unsigned TIMEOUT_CYC = 6000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rise_i,
  output sreq_state_e state_o,
  output logic        launch_o,
  output logic        capture_o,
  output logic        last_o,
  output logic        valid_o,
  output logic        err_o,
  output logic        busy_o
);

  localparam int unsigned CNT_W   = $clog2(DATA_W);
  localparam int unsigned TMR_MAX = (PERIOD_CYC > TIMEOUT_CYC) ? PERIOD_CYC : TIMEOUT_CYC;
  localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);
  localparam logic [TMR_W-1:0] PER_LAST = TMR_W'(PERIOD_CYC - 1);
  localparam logic [TMR_W-1:0] TO_LAST  = TMR_W'(TIMEOUT_CYC - 1);

  sreq_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             valid_q, valid_d;
  logic             err_q, err_d;
  logic             in_reply;

  assign in_reply = (state_q == ST_WAIT) || (state_q == ST_RX);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    launch_o = 1'b0;
    valid_d  = 1'b0;
    err_d    = 1'b0;
    last_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (tmr_q == PER_LAST) begin
          launch_o = 1'b1;
          state_d  = ST_TX;
        end
      end
      ST_TX: begin
        if (rise_i) begin
          if (cnt_q == CNT_LAST) begin
            cnt_d   = '0;
            state_d = ST_WAIT;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (rise_i) begin
          cnt_d   = CNT_W'(1);
          state_d = ST_RX;
        end else if (tmr_q == TO_LAST) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_RX: begin
        if (rise_i) begin
          if (cnt_q == CNT_LAST) begin
            last_o  = 1'b1;
            valid_d = 1'b1;
            cnt_d   = '0;
            state_d = ST_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end else if (tmr_q == TO_LAST) begin
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if ((state_d != state_q) || (in_reply && rise_i)) begin
      tmr_d = '0;
    end else if (state_q == ST_TX) begin
      tmr_d = tmr_q;
    end else begin
      tmr_d = tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      tmr_q   <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      tmr_q   <= tmr_d;
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  assign state_o   = state_q;
  assign capture_o = in_reply & rise_i;
  assign valid_o   = valid_q;
  assign err_o     = err_q;
  assign busy_o    = (state_q != ST_IDLE);

  // R6: completion strobe is a single cycle
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R9: busy is already low when completion is reported
  p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !busy_o);

  // R8: timeout reports once and leaves the block idle
  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!busy_o && !valid_o) ##1 !err_o);

  // R2: an exchange only starts from the idle phase
  p_launch_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(state_q == ST_IDLE));

endmodule

// File: rtl/sreq_port.sv
module sreq_port
  import sreq_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned PERIOD_CYC  = 50000,
  parameter int unsigned TIMEOUT_CYC = 6000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  output logic              ser_dat_o,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              busy_o,
  output logic              err_o
);

  logic        rst_q;
  logic        rst_int_n;
  logic [1:0]  pins_s;
  logic        sclk_s, sdat_s, sclk_prev_q;
  logic        rise, fall;
  sreq_state_e state;
  logic        launch, capture, last;

  sreq_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (1'b1),
    .q_o   (rst_q)
  );
  assign rst_int_n = rst_q;

  sreq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   ({ser_clk_i, ser_dat_i}),
    .q_o   (pins_s)
  );
  assign sclk_s = pins_s[1];
  assign sdat_s = pins_s[0];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sclk_prev_q <= 1'b1;
    end else begin
      sclk_prev_q <= sclk_s;
    end
  end

  assign rise = sclk_s & ~sclk_prev_q;
  assign fall = ~sclk_s & sclk_prev_q;

  sreq_seq #(
    .DATA_W      (DATA_W),
    .PERIOD_CYC  (PERIOD_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rise_i    (rise),
    .state_o   (state),
    .launch_o  (launch),
    .capture_o (capture),
    .last_o    (last),
    .valid_o   (rx_valid_o),
    .err_o     (err_o),
    .busy_o    (busy_o)
  );

  sreq_txshift #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_i   (launch),
    .byte_i   (tx_byte_i),
    .active_i (state == ST_TX),
    .shift_i  (fall),
    .dat_o    (ser_dat_o)
  );

  sreq_rxshift #(.DATA_W(DATA_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .capture_i (capture),
    .last_i    (last),
    .bit_i     (sdat_s),
    .byte_o    (rx_byte_o)
  );

endmodule

// File: tb/sreq_port_tb_top.sv
module sreq_port_tb_top;

  localparam int W    = 8;
  localparam int PER  = 40;
  localparam int TO   = 6000;
  localparam int HALF = 6;
  localparam int WDOG = 190000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ser_clk = 1'b1;
  logic         ser_din = 1'b0;
  logic         ser_dout;
  logic [W-1:0] tx_byte = '0;
  logic [W-1:0] rx_byte;
  logic         rx_valid, busy, err;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int vcount = 0, ecount = 0;
  logic [W-1:0] vbyte = '0;
  logic         prev_valid = 1'b0, prev_err = 1'b0, prev_busy = 1'b0;
  logic         seen_idle_end = 1'b0;
  int           low_run = 0;
  bit           finished = 1'b0;

  always #10 clk = ~clk;

  sreq_port #(.DATA_W(W), .PERIOD_CYC(PER), .TIMEOUT_CYC(TO), .SYNC_STAGES(2)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_clk_i  (ser_clk),
    .ser_dat_i  (ser_din),
    .ser_dat_o  (ser_dout),
    .tx_byte_i  (tx_byte),
    .rx_byte_o  (rx_byte),
    .rx_valid_o (rx_valid),
    .busy_o     (busy),
    .err_o      (err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Output monitor, sampled on falling system clock edges
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (rx_valid) begin
        vcount++;
        vbyte = rx_byte;
        check(!busy, "R9 busy low at valid", busy, 0);
      end
      if (rx_valid && prev_valid) check(1'b0, "R6 valid width", 2, 1);
      if (err) ecount++;
      if (err && prev_err) check(1'b0, "R8 err width", 2, 1);
      if (!busy) low_run++;
      if (busy && !prev_busy) begin
        if (seen_idle_end) check(low_run == PER, "R2 idle length", low_run, PER);
        low_run = 0;
      end
      if (!busy && prev_busy) seen_idle_end = 1'b1;
      prev_valid = rx_valid;
      prev_err   = err;
      prev_busy  = busy;
    end
    if (cyc > WDOG && !finished) begin
      finished = 1'b1;
      check(1'b0, "watchdog", cyc, WDOG);
      summary();
    end
  end

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // One exchange as seen by the far device
  task automatic exchange(input logic [W-1:0] txv, input logic [W-1:0] rxv,
                          input int delay, input bit reply);
    logic [W-1:0] got;
    int v0, e0, waited;
    got = '0;
    tx_byte = txv;
    while (!busy) @(negedge clk);
    check(ser_dout == 1'b1, "R4 high before first fall", ser_dout, 1);
    tx_byte = ~txv ^ 8'h5A;
    for (int b = 0; b < W; b++) begin
      ser_clk = 1'b0;
      wait_cyc(HALF);
      got = {got[W-2:0], ser_dout};
      check(busy == 1'b1, "R9 busy in transmit", busy, 1);
      ser_clk = 1'b1;
      wait_cyc(HALF);
    end
    check(got == txv, "R3/R5 transmitted byte", got, txv);
    v0 = vcount;
    e0 = ecount;
    if (!reply) begin
      waited = HALF;
      while (ecount == e0 && waited < TO + 40) begin
        @(negedge clk);
        waited++;
        if (waited == HALF + 10) check(ser_dout == 1'b1, "R4 high while waiting", ser_dout, 1);
      end
      check(waited >= TO && waited <= TO + 10, "R8 timeout window", waited, TO);
      check(vcount == v0, "R8 no valid on timeout", vcount - v0, 0);
      check(ecount == e0 + 1, "R8 error pulse", ecount - e0, 1);
      check(busy == 1'b0, "R8 idle after timeout", busy, 0);
      return;
    end
    wait_cyc(delay);
    check(busy == 1'b1, "R9 busy while waiting", busy, 1);
    check(ser_dout == 1'b1, "R4 high while waiting", ser_dout, 1);
    for (int b = W - 1; b >= 0; b--) begin
      ser_clk = 1'b0;
      ser_din = rxv[b];
      wait_cyc(HALF);
      ser_clk = 1'b1;
      wait_cyc(HALF);
    end
    check(vcount == v0 + 1, "R6 one valid per reply", vcount - v0, 1);
    check(vbyte == rxv, "R6/R7 received byte", vbyte, rxv);
    check(ecount == e0, "R7 no error on valid reply", ecount - e0, 0);
  endtask

  initial begin
    logic [W-1:0] tv, rv;
    int dl;
    wait_cyc(3);
    check(busy == 0 && rx_valid == 0 && err == 0, "R1 reset outputs", busy, 0);
    check(ser_dout == 1'b1, "R1 reset line high", ser_dout, 1);
    rst_n = 1'b1;
    wait_cyc(PER / 2);
    check(busy == 0 && rx_valid == 0 && err == 0 && ser_dout == 1, "R1 before launch", busy, 0);
    for (int i = 0; i < 40; i++) begin
      if (i < 8) tv = W'(1) << i;
      else if (i < 16) tv = ~(W'(1) << (i - 8));
      else tv = W'(i * 37 + 11);
      rv = W'(i * 91 + 200) ^ {W{i[0]}};
      if (i == 5) dl = 5000;
      else if (i % 8 == 3) dl = 500;
      else dl = 20 + i;
      exchange(tv, rv, dl, 1'b1);
      if (i == 12 || i == 30) exchange(tv ^ 8'h3C, '0, 0, 1'b0);
    end
    exchange(8'h00, 8'hFF, TO - 100, 1'b1);
    exchange(8'hFF, 8'h00, 10, 1'b1);
    finished = 1'b1;
    summary();
  end

endmodule